// File: doc/BRIEF.md
# Receive Payload Checksum Accumulator

This block watches a receive frame pass by as a stream of bytes, one byte per accepted cycle, framed by a start marker and an end marker. It forms a 16-bit ones'-complement style sum over everything after the 14-byte link header and before the 4-byte trailing check sequence. Bytes are taken in pairs, and within each pair the byte that arrived later is the upper half of the word. Every addition folds its carry straight back into the low bit.

Whether a byte belongs to the trailer is only known once the frame ends. For this reason each byte waits in a short delay line before it reaches the adder. When the end marker arrives, the bytes still waiting are dropped. One cycle after the last byte, the block presents the sum with a one-cycle strobe. It also flags a frame that is too short to hold both the header and the trailer. Nothing is stored: the block only taps a stream that is on its way elsewhere.

Top module: `rx_payload_csum`

## Requirements
- R1: The result appears on `sum_value` and `sum_short` in the cycle after the byte carrying `in_last` is accepted. `sum_valid` is high for exactly that one cycle.
- R2: The first 14 accepted bytes of a frame (offsets 0 to 13) do not contribute to the sum.
- R3: The final 4 bytes of a frame do not contribute to the sum, for any frame length.
- R4: Summed bytes are paired in arrival order. Each word is (later byte × 256) + earlier byte.
- R5: Any carry out of bit 15 of an addition is added back into bit 0 of the running sum at once.
- R6: If the summed region has an odd byte count, its last byte is added as a word whose upper byte is zero.
- R7: A frame shorter than 18 bytes reports `sum_short`=1 and `sum_value`=0. A frame of exactly 18 bytes reports `sum_short`=0 and `sum_value`=0.
- R8: An accepted byte with `in_first`=1 starts a new frame at offset 0 and discards all sum, pairing and length state, even in the middle of an unfinished frame.
- R9: Cycles with `in_valid`=0 have no effect on the result. `sum_value` and `sum_short` hold their last values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on `in_data` this cycle |
| in_first | input | 1 | Accepted byte is the first of a frame |
| in_last | input | 1 | Accepted byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| sum_valid | output | 1 | One-cycle strobe: result fields are new |
| sum_value | output | 16 | End-around-carry sum of the payload |
| sum_short | output | 1 | Frame too short for header plus trailer |

## Verification
Random frames of 1 to 300 bytes, with random idle gaps, are compared against a bench model. Even and odd payload lengths separate correct pairing from a missing or misplaced zero pad. Random byte values expose a swapped byte order inside the word. Directed frames are also used:
- all-0xFF payloads force a carry on nearly every addition, which catches a lost end-around carry;
- lengths 17, 18 and 19 sit on the short-frame boundary;
- a frame cut off mid-way and followed by a fresh start shows whether stale sum or pairing state leaks into the next result.

// File: rtl/rx_payload_csum.sv
module rx_payload_csum #(
  parameter int HDR_BYTES  = 14,
  parameter int TAIL_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  output logic        sum_valid,
  output logic [15:0] sum_value,
  output logic        sum_short
);

  localparam int MIN_LEN = HDR_BYTES + TAIL_BYTES;
  localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] LAST_MIN = CNT_W'(MIN_LEN - 1);

  function automatic logic [15:0] add_fold(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [7:0]       dly [TAIL_BYTES];
  logic [15:0]      acc;
  logic [7:0]       lo_byte;
  logic             lo_pend;

  logic [CNT_W-1:0] cnt_eff;
  logic [15:0]      acc_base, acc_nx, fin_sum;
  logic             pend_base, pend_nx, take, short_nx;
  logic [7:0]       lo_nx, exit_b;

  assign cnt_eff   = in_first ? '0 : cnt;
  assign acc_base  = in_first ? 16'd0 : acc;
  assign pend_base = in_first ? 1'b0 : lo_pend;
  assign exit_b    = dly[TAIL_BYTES-1];
  assign take      = cnt_eff >= MIN_CNT;
  assign short_nx  = cnt_eff < LAST_MIN;

  always_comb begin
    acc_nx  = acc_base;
    pend_nx = pend_base;
    lo_nx   = lo_byte;
    if (take) begin
      if (pend_base) begin
        acc_nx  = add_fold(acc_base, {exit_b, lo_byte});
        pend_nx = 1'b0;
      end else begin
        lo_nx   = exit_b;
        pend_nx = 1'b1;
      end
    end
  end

  assign fin_sum = pend_nx ? add_fold(acc_nx, {8'h00, lo_nx}) : acc_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly[0] <= '0;
    else if (in_valid) dly[0] <= in_data;
  end

  for (genvar i = 1; i < TAIL_BYTES; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly[i] <= '0;
      else if (in_valid) dly[i] <= dly[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      lo_byte <= '0;
      lo_pend <= 1'b0;
    end else if (in_valid) begin
      lo_byte <= lo_nx;
      if (in_last) begin
        cnt     <= '0;
        acc     <= '0;
        lo_pend <= 1'b0;
      end else begin
        cnt     <= (&cnt_eff) ? cnt_eff : cnt_eff + 1'b1;
        acc     <= acc_nx;
        lo_pend <= pend_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_valid <= 1'b0;
      sum_value <= '0;
      sum_short <= 1'b0;
    end else begin
      sum_valid <= in_valid && in_last;
      if (in_valid && in_last) begin
        sum_short <= short_nx;
        sum_value <= short_nx ? 16'd0 : fin_sum;
      end
    end
  end

endmodule

// File: rtl/rx_payload_csum_chk.sv
module rx_payload_csum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_last,
  input logic        sum_valid,
  input logic [15:0] sum_value,
  input logic        sum_short
);

  a_r1_strobe_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> sum_valid);

  a_r1_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !sum_valid);

  a_r7_short_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_valid && sum_short) |-> (sum_value == 16'd0));

  a_r9_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> ($stable(sum_value) && $stable(sum_short)));

endmodule

bind rx_payload_csum rx_payload_csum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .sum_valid(sum_valid), .sum_value(sum_value), .sum_short(sum_short)
);

// File: tb/rx_payload_csum_tb.sv
module rx_payload_csum_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic sum_valid, sum_short;
  logic [15:0] sum_value;

  int n_tests = 0, n_fail = 0;
  logic [7:0] frm [512];
  int gap_pct = 0;

  always #2 clk = ~clk;

  rx_payload_csum u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .sum_valid(sum_valid),
    .sum_value(sum_value), .sum_short(sum_short)
  );

  function automatic logic [15:0] model_sum(input int len);
    int acc = 0;
    int w;
    if (len < 18) return 16'd0;
    for (int i = 14; i < len - 4; i += 2) begin
      w = (i + 1 < len - 4) ? (int'(frm[i+1]) * 256 + int'(frm[i])) : int'(frm[i]);
      acc += w;
      if (acc > 32'hFFFF) acc = (acc & 32'hFFFF) + 1;
    end
    return acc[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic f, input logic l, input logic [7:0] d);
    while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_last = l; in_data = d;
  endtask

  task automatic send(input int len, input string req);
    logic [15:0] exp;
    exp = model_sum(len);
    for (int i = 0; i < len; i++) put_byte(i == 0, i == len - 1, frm[i]);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    check({req, " R1 strobe"}, sum_valid, 1);
    check({req, " R7 short flag"}, sum_short, len < 18);
    check({req, " sum"}, sum_value, exp);
    @(negedge clk);
    check({req, " R1 single cycle"}, sum_valid, 0);
    check({req, " R9 hold"}, sum_value, exp);
  endtask

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    #8;
    check("reset valid", sum_valid, 0);
    check("reset value", sum_value, 0);
    check("reset short", sum_short, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 512; i++) frm[i] = 8'($urandom);
    send(17, "R7 len17");
    send(18, "R7 len18");
    send(19, "R6 len19 odd");
    send(1, "R7 len1");

    for (int i = 0; i < 512; i++) frm[i] = (i < 14 || i >= 100) ? 8'h5A : 8'hFF;
    send(104, "R5 carries");

    for (int i = 0; i < 512; i++) frm[i] = 8'h00;
    frm[14] = 8'h01; frm[15] = 8'h02;
    send(20, "R4 byte order");
    for (int i = 0; i < 14; i++) frm[i] = 8'hEE;
    for (int i = 16; i < 20; i++) frm[i] = 8'hCC;
    send(20, "R2 R3 header and trailer");

    for (int i = 0; i < 512; i++) frm[i] = 8'($urandom);
    for (int i = 0; i < 25; i++) put_byte(i == 0, 1'b0, 8'($urandom));
    send(41, "R8 restart");

    gap_pct = 30;
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 512; i++) frm[i] = 8'($urandom);
      send(1 + int'($urandom % 300), "R9 random gaps");
    end
    gap_pct = 0;
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < 512; i++) frm[i] = 8'($urandom);
      send(14 + int'($urandom % 40), "R6 random short-range");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule